// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the state machine that puts a small microcontroller core into one of its low-power states and brings it back out. A sleep request comes with a flag that picks the wait-for-interrupt or wait-for-event style. Return-from-interrupt with sleep-on-exit enabled is presented on the same request with the flag cleared. The deep-sleep flag, a 3-bit depth code, the low-power-regulator request, the retention bit and the stop-wake clock bit decide which state is entered. From that state the block drives the CPU and peripheral clock gates, the four oscillator enables, and the enables of the main and low-power regulators.

Each deep state accepts only its own wake sources and ignores the rest. Leaving a stop level waits for the regulator-ready handshake and then the oscillator-ready handshake before the clocks are ungated. Leaving standby or shutdown follows the same path and then raises a one-cycle system reset request. A sticky flag records which of those two states was left. The block also reports the system clock that software will run from after wake-up.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in normal run: CPU and peripheral clocks ungated, both regulators on, multi-speed and both low-speed oscillators on, the 16 MHz oscillator off, sysClkSel = 2 (multi-speed at 4 MHz), sysRstReq low and exitFlags = 0.
- R2: A sleep request with deepSleep and lpRegReq low gates only the CPU clock and keeps both regulators on. With sleepOnEvt = 0 only irqPend wakes it, and with sleepOnEvt = 1 only evtPend wakes it. sysClkSel does not change.
- R3: With no sleep request, lpRegReq high in run enters low-power run: the main regulator is off, the low-power regulator is on and the CPU clock runs. lpRegReq low in that state returns to run.
- R4: A sleep request with deepSleep low and lpRegReq high gates the CPU clock with the main regulator off and the low-power regulator on. It wakes by the rules of R2 and returns to low-power run.
- R5: With deepSleep high, modeSel 000 enters the stop level that keeps the main regulator on, and 001 and 010 enter the stop levels with it off. In every stop level the low-power regulator, the 16 MHz oscillator and both low-speed oscillators are on, and all other oscillators and clocks are off. Only extiWake leaves a stop level.
- R6: On stop entry sysClkSel becomes 1 (16 MHz oscillator) if stopWakeHsi is 1, and 0 (multi-speed oscillator at its previous frequency) if it is 0. The oscillator enabled after wake-up follows that selection.
- R7: With deepSleep high, modeSel 011 enters standby with only the low-speed oscillators on. The low-power regulator stays on if retainRam is 1, and both regulators are off if it is 0. Any set bit of wakeSrc wakes it, while irqPend, evtPend and extiWake are ignored. sysClkSel becomes 2.
- R8: With deepSleep high, any modeSel of the form 1xx enters shutdown, with both regulators off and only the low-speed external oscillator on. Only wakeSrc bits 3 (wake pin edge), 4 (real-time clock or tamper) and 6 (external reset pin) wake it. sysClkSel becomes 2.
- R9: On any exit from a stop level, standby or shutdown, the clocks stay gated with the main regulator on until regRdy has been seen, then until oscRdy has been seen, in that order.
- R10: After an exit from standby or shutdown, sysRstReq is high for exactly one cycle before run. The exit sets exitFlags bit 0 (standby) or bit 1 (shutdown). A flag stays set until a 1 is written to the same bit of flagClr, and a set on the same edge wins over the clear.
- R11: A sleep request whose own wake-up condition is already present is dropped and the state does not change. For sleep states this is the selected irqPend or evtPend, for stop levels extiWake, for standby any wakeSrc bit, and for shutdown an allowed wakeSrc bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | One-cycle sleep request (WFI, WFE or sleep-on-exit return) |
| sleepOnEvt | input | 1 | 1: request is wait-for-event; 0: wait-for-interrupt style |
| deepSleep | input | 1 | Selects the deep states |
| modeSel | input | 3 | Deep-state depth code |
| lpRegReq | input | 1 | Low-power regulator request |
| retainRam | input | 1 | Keep low-power regulator on in standby |
| stopWakeHsi | input | 1 | Stop wake clock: 1 = 16 MHz oscillator |
| irqPend | input | 1 | Any interrupt pending |
| evtPend | input | 1 | Wake-up event pending |
| extiWake | input | 1 | Enabled external line or peripheral wake event |
| wakeSrc | input | NUM_WAKE_SRC | Standby and shutdown wake lines |
| regRdy | input | 1 | Regulator ready handshake |
| oscRdy | input | 1 | Selected oscillator ready handshake |
| flagClr | input | 2 | Write-one-to-clear for exitFlags |
| cpuClkEn | output | 1 | CPU clock gate enable |
| periphClkEn | output | 1 | Peripheral clock gate enable |
| mainRegEn | output | 1 | Main regulator enable |
| lpRegEn | output | 1 | Low-power regulator enable |
| hsiEn | output | 1 | 16 MHz internal oscillator enable |
| msiEn | output | 1 | Multi-speed oscillator enable |
| lsiEn | output | 1 | Low-speed internal oscillator enable |
| lseEn | output | 1 | Low-speed external oscillator enable |
| sysClkSel | output | 2 | Wake clock: 0 multi-speed kept, 1 16 MHz, 2 multi-speed 4 MHz |
| sysRstReq | output | 1 | One-cycle system reset request |
| exitFlags | output | 2 | Sticky: bit 0 standby exit, bit 1 shutdown exit |

## Verification
The bench builds the block with its default eight wake lines and the shutdown mask that allows bits 3, 4 and 6. With those values every standby source can be driven, and a mixed pattern of five disallowed bits can be offered in shutdown before one allowed bit. The same parameters let each stop level, both standby variants and two shutdown codes be reached from one run. Between them they show the two handshakes being taken in order, the reset pulse after a cold exit, and a flag set winning over a clear on the same edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_MSI_KEEP = 2'd0;
  localparam logic [SEL_W-1:0] SEL_HSI      = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MSI_4M   = 2'd2;

  localparam int FLAG_SBY  = 0;
  localparam int FLAG_SHDN = 1;
  localparam int NUM_FLAGS = 2;

  typedef enum logic [3:0] {
    ST_RUN, ST_LPRUN, ST_SLEEP, ST_LPSLEEP,
    ST_STOP_MR, ST_STOP_LP, ST_SBY_RET, ST_SBY, ST_SHDN,
    ST_WAKE_REG, ST_WAKE_OSC, ST_RST_REQ
  } pwrState_e;

  typedef struct packed {
    logic                 loadSel;
    logic [SEL_W-1:0]     selVal;
    logic [NUM_FLAGS-1:0] setFlag;
  } pwrStrobe_t;

endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NUM_WAKE_SRC = 8,
  parameter logic [NUM_WAKE_SRC-1:0] SHDN_WAKE_MASK = 8'h58
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sleepReq,
  input  logic                    sleepOnEvt,
  input  logic                    deepSleep,
  input  logic [2:0]              modeSel,
  input  logic                    lpRegReq,
  input  logic                    retainRam,
  input  logic                    stopWakeHsi,
  input  logic                    irqPend,
  input  logic                    evtPend,
  input  logic                    extiWake,
  input  logic [NUM_WAKE_SRC-1:0] wakeSrc,
  input  logic                    regRdy,
  input  logic                    oscRdy,
  output pwrState_e               stateQ,
  output pwrStrobe_t              strobe
);

  pwrState_e stateD, entryTgt;
  logic wfeQ, wfeD, coldQ, coldD;
  logic entryBlocked, shallowWake, anySby, anyShdn;
  logic [SEL_W-1:0] entrySel;
  logic entryLoad;

  assign anySby      = |wakeSrc;
  assign anyShdn     = |(wakeSrc & SHDN_WAKE_MASK);
  assign shallowWake = wfeQ ? evtPend : irqPend;

  // Target of a sleep request, and whether its wake condition already holds
  always_comb begin
    entryTgt     = ST_RUN;
    entryBlocked = 1'b0;
    entryLoad    = 1'b0;
    entrySel     = SEL_MSI_4M;
    if (!deepSleep) begin
      entryTgt     = lpRegReq ? ST_LPSLEEP : ST_SLEEP;
      entryBlocked = sleepOnEvt ? evtPend : irqPend;
    end else if (modeSel[2]) begin
      entryTgt     = ST_SHDN;
      entryBlocked = anyShdn;
      entryLoad    = 1'b1;
    end else if (modeSel[1:0] == 2'b11) begin
      entryTgt     = retainRam ? ST_SBY_RET : ST_SBY;
      entryBlocked = anySby;
      entryLoad    = 1'b1;
    end else begin
      entryTgt     = (modeSel[1:0] == 2'b00) ? ST_STOP_MR : ST_STOP_LP;
      entryBlocked = extiWake;
      entryLoad    = 1'b1;
      entrySel     = stopWakeHsi ? SEL_HSI : SEL_MSI_KEEP;
    end
  end

  always_comb begin
    stateD = stateQ;
    wfeD   = wfeQ;
    coldD  = coldQ;
    strobe = '0;
    unique case (stateQ)
      ST_RUN, ST_LPRUN: begin
        if (sleepReq) begin
          if (!entryBlocked) begin
            stateD         = entryTgt;
            wfeD           = sleepOnEvt;
            strobe.loadSel = entryLoad;
            strobe.selVal  = entrySel;
          end
        end else if ((stateQ == ST_RUN) && lpRegReq) begin
          stateD = ST_LPRUN;
        end else if ((stateQ == ST_LPRUN) && !lpRegReq) begin
          stateD = ST_RUN;
        end
      end
      ST_SLEEP:   if (shallowWake) stateD = ST_RUN;
      ST_LPSLEEP: if (shallowWake) stateD = ST_LPRUN;
      ST_STOP_MR, ST_STOP_LP: begin
        if (extiWake) begin
          stateD = ST_WAKE_REG;
          coldD  = 1'b0;
        end
      end
      ST_SBY_RET, ST_SBY: begin
        if (anySby) begin
          stateD                   = ST_WAKE_REG;
          coldD                    = 1'b1;
          strobe.setFlag[FLAG_SBY] = 1'b1;
        end
      end
      ST_SHDN: begin
        if (anyShdn) begin
          stateD                    = ST_WAKE_REG;
          coldD                     = 1'b1;
          strobe.setFlag[FLAG_SHDN] = 1'b1;
        end
      end
      ST_WAKE_REG: if (regRdy) stateD = ST_WAKE_OSC;
      ST_WAKE_OSC: if (oscRdy) stateD = coldQ ? ST_RST_REQ : ST_RUN;
      ST_RST_REQ:  stateD = ST_RUN;
      default:     stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_RUN;
      wfeQ   <= 1'b0;
      coldQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      wfeQ   <= wfeD;
      coldQ  <= coldD;
    end
  end

  // R5: a stop level is held unless the external wake line is seen
  p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_STOP_MR || stateQ == ST_STOP_LP) && !extiWake) |=> (stateQ == $past(stateQ)));

  // R9: the oscillator wait is only reached after the regulator wait saw regRdy
  p_reg_before_osc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAKE_OSC && $past(stateQ) != ST_WAKE_OSC) |-> ($past(stateQ) == ST_WAKE_REG && $past(regRdy)));

endmodule

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pwrState_e            stateQ,
  input  pwrStrobe_t           strobe,
  input  logic [NUM_FLAGS-1:0] flagClr,
  input  logic                 oscRdy,
  output logic                 cpuClkEn,
  output logic                 periphClkEn,
  output logic                 mainRegEn,
  output logic                 lpRegEn,
  output logic                 hsiEn,
  output logic                 msiEn,
  output logic                 lsiEn,
  output logic                 lseEn,
  output logic [SEL_W-1:0]     sysClkSel,
  output logic                 sysRstReq,
  output logic [NUM_FLAGS-1:0] exitFlags
);

  logic [SEL_W-1:0] selQ;
  logic selHsi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               selQ <= SEL_MSI_4M;
    else if (strobe.loadSel) selQ <= strobe.selVal;
  end

  generate
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) exitFlags[f] <= 1'b0;
        else       exitFlags[f] <= strobe.setFlag[f] | (exitFlags[f] & ~flagClr[f]);
      end
    end
  endgenerate

  assign sysClkSel = selQ;
  assign selHsi    = (selQ == SEL_HSI);

  always_comb begin
    cpuClkEn    = 1'b0;
    periphClkEn = 1'b0;
    mainRegEn   = 1'b1;
    lpRegEn     = 1'b1;
    hsiEn       = selHsi;
    msiEn       = !selHsi;
    lsiEn       = 1'b1;
    lseEn       = 1'b1;
    sysRstReq   = 1'b0;
    unique case (stateQ)
      ST_RUN:     begin cpuClkEn = 1'b1; periphClkEn = 1'b1; end
      ST_LPRUN:   begin cpuClkEn = 1'b1; periphClkEn = 1'b1; mainRegEn = 1'b0; end
      ST_SLEEP:   periphClkEn = 1'b1;
      ST_LPSLEEP: begin periphClkEn = 1'b1; mainRegEn = 1'b0; end
      ST_STOP_MR, ST_STOP_LP: begin
        mainRegEn = (stateQ == ST_STOP_MR);
        hsiEn     = 1'b1;
        msiEn     = 1'b0;
      end
      ST_SBY_RET, ST_SBY: begin
        mainRegEn = 1'b0;
        lpRegEn   = (stateQ == ST_SBY_RET);
        hsiEn     = 1'b0;
        msiEn     = 1'b0;
      end
      ST_SHDN: begin
        mainRegEn = 1'b0;
        lpRegEn   = 1'b0;
        hsiEn     = 1'b0;
        msiEn     = 1'b0;
        lsiEn     = 1'b0;
      end
      ST_RST_REQ: sysRstReq = 1'b1;
      default: ;
    endcase
  end

  // R10: the reset request never lasts beyond one cycle
  p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> !sysRstReq);

  // R10: an exit flag only falls when software writes a one to it
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (exitFlags[FLAG_SBY] && !flagClr[FLAG_SBY]) |=> exitFlags[FLAG_SBY]);

  // R3: the CPU never runs without some regulator up
  p_cpu_has_reg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && !mainRegEn) |-> lpRegEn);

  // R9: peripheral clocks return only after oscillator ready, or after the reset pulse
  p_gate_after_osc_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(periphClkEn) && !$past(sysRstReq)) |-> $past(oscRdy));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_WAKE_SRC = 8,
  parameter logic [NUM_WAKE_SRC-1:0] SHDN_WAKE_MASK = 8'h58
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sleepReq,
  input  logic                    sleepOnEvt,
  input  logic                    deepSleep,
  input  logic [2:0]              modeSel,
  input  logic                    lpRegReq,
  input  logic                    retainRam,
  input  logic                    stopWakeHsi,
  input  logic                    irqPend,
  input  logic                    evtPend,
  input  logic                    extiWake,
  input  logic [NUM_WAKE_SRC-1:0] wakeSrc,
  input  logic                    regRdy,
  input  logic                    oscRdy,
  input  logic [1:0]              flagClr,
  output logic                    cpuClkEn,
  output logic                    periphClkEn,
  output logic                    mainRegEn,
  output logic                    lpRegEn,
  output logic                    hsiEn,
  output logic                    msiEn,
  output logic                    lsiEn,
  output logic                    lseEn,
  output logic [1:0]              sysClkSel,
  output logic                    sysRstReq,
  output logic [1:0]              exitFlags
);

  pwrState_e  stateQ;
  pwrStrobe_t strobe;

  pwr_seq_ctrl #(
    .NUM_WAKE_SRC  (NUM_WAKE_SRC),
    .SHDN_WAKE_MASK(SHDN_WAKE_MASK)
  ) ctrl_i (
    .clk, .rstN, .sleepReq, .sleepOnEvt, .deepSleep, .modeSel, .lpRegReq,
    .retainRam, .stopWakeHsi, .irqPend, .evtPend, .extiWake, .wakeSrc,
    .regRdy, .oscRdy, .stateQ, .strobe
  );

  pwr_seq_dp dp_i (
    .clk, .rstN, .stateQ, .strobe, .flagClr, .oscRdy,
    .cpuClkEn, .periphClkEn, .mainRegEn, .lpRegEn, .hsiEn, .msiEn, .lsiEn,
    .lseEn, .sysClkSel, .sysRstReq, .exitFlags
  );

endmodule

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq, sleepOnEvt, deepSleep, lpRegReq, retainRam, stopWakeHsi;
  logic irqPend, evtPend, extiWake, regRdy, oscRdy;
  logic [2:0] modeSel;
  logic [7:0] wakeSrc;
  logic [1:0] flagClr;
  logic cpuClkEn, periphClkEn, mainRegEn, lpRegEn, hsiEn, msiEn, lsiEn, lseEn;
  logic [1:0] sysClkSel, exitFlags;
  logic sysRstReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_seq dut_i (
    .clk, .rstN, .sleepReq, .sleepOnEvt, .deepSleep, .modeSel, .lpRegReq,
    .retainRam, .stopWakeHsi, .irqPend, .evtPend, .extiWake, .wakeSrc,
    .regRdy, .oscRdy, .flagClr, .cpuClkEn, .periphClkEn, .mainRegEn, .lpRegEn,
    .hsiEn, .msiEn, .lsiEn, .lseEn, .sysClkSel, .sysRstReq, .exitFlags
  );

  // Row: slp(2: 01 wfi, 10 wfe) deep modeSel {lpReg,retain,hsiSel} {irq,evt,exti}
  //      wakeSrc {regRdy,oscRdy} flagClr | out{cpu,per,mr,lp,hsi,msi,lsi,lse} sel {rst,shdnF,sbyF}
  localparam int NV = 46;
  localparam logic [36:0] VEC [NV] = '{
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b00,2'b00, 8'b11110111,2'd2,3'b000}, // R1 idle run
    {2'b01,1'b0,3'b000,3'b000,3'b000,8'h00,2'b00,2'b00, 8'b01110111,2'd2,3'b000}, // R2 wfi sleep
    {2'b00,1'b0,3'b000,3'b000,3'b010,8'h00,2'b00,2'b00, 8'b01110111,2'd2,3'b000}, // R2 evt ignored
    {2'b00,1'b0,3'b000,3'b000,3'b100,8'h00,2'b00,2'b00, 8'b11110111,2'd2,3'b000}, // R2 irq wakes
    {2'b10,1'b0,3'b000,3'b000,3'b010,8'h00,2'b00,2'b00, 8'b11110111,2'd2,3'b000}, // R11 wfe blocked
    {2'b10,1'b0,3'b000,3'b000,3'b000,8'h00,2'b00,2'b00, 8'b01110111,2'd2,3'b000}, // R2 wfe sleep
    {2'b00,1'b0,3'b000,3'b000,3'b100,8'h00,2'b00,2'b00, 8'b01110111,2'd2,3'b000}, // R2 irq ignored
    {2'b00,1'b0,3'b000,3'b000,3'b010,8'h00,2'b00,2'b00, 8'b11110111,2'd2,3'b000}, // R2 evt wakes
    {2'b00,1'b0,3'b000,3'b100,3'b000,8'h00,2'b00,2'b00, 8'b11010111,2'd2,3'b000}, // R3 lp run
    {2'b01,1'b0,3'b000,3'b100,3'b000,8'h00,2'b00,2'b00, 8'b01010111,2'd2,3'b000}, // R4 lp sleep
    {2'b00,1'b0,3'b000,3'b100,3'b100,8'h00,2'b00,2'b00, 8'b11010111,2'd2,3'b000}, // R4 back to lp run
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b00,2'b00, 8'b11110111,2'd2,3'b000}, // R3 exit
    {2'b01,1'b1,3'b010,3'b000,3'b001,8'h00,2'b00,2'b00, 8'b11110111,2'd2,3'b000}, // R11 stop blocked
    {2'b01,1'b1,3'b000,3'b001,3'b000,8'h00,2'b00,2'b00, 8'b00111011,2'd1,3'b000}, // R5 R6 stop0
    {2'b00,1'b0,3'b000,3'b000,3'b110,8'hff,2'b00,2'b00, 8'b00111011,2'd1,3'b000}, // R5 others ignored
    {2'b00,1'b0,3'b000,3'b000,3'b001,8'h00,2'b00,2'b00, 8'b00111011,2'd1,3'b000}, // R9 wait reg
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b01,2'b00, 8'b00111011,2'd1,3'b000}, // R9 osc early
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b10,2'b00, 8'b00111011,2'd1,3'b000}, // R9 reg ready
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b01,2'b00, 8'b11111011,2'd1,3'b000}, // R6 run on hsi
    {2'b10,1'b1,3'b001,3'b000,3'b000,8'h00,2'b00,2'b00, 8'b00011011,2'd0,3'b000}, // R5 stop1
    {2'b00,1'b0,3'b000,3'b000,3'b001,8'h00,2'b00,2'b00, 8'b00110111,2'd0,3'b000}, // R9 wait reg
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b11,2'b00, 8'b00110111,2'd0,3'b000}, // R9 wait osc
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b01,2'b00, 8'b11110111,2'd0,3'b000}, // R6 msi kept
    {2'b01,1'b1,3'b010,3'b000,3'b000,8'h00,2'b00,2'b00, 8'b00011011,2'd0,3'b000}, // R5 stop2
    {2'b00,1'b0,3'b000,3'b000,3'b001,8'h00,2'b11,2'b00, 8'b00110111,2'd0,3'b000}, // R9
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b11,2'b00, 8'b00110111,2'd0,3'b000}, // R9
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b11,2'b00, 8'b11110111,2'd0,3'b000}, // R9 run
    {2'b01,1'b1,3'b011,3'b010,3'b000,8'h00,2'b00,2'b00, 8'b00010011,2'd2,3'b000}, // R7 standby ret
    {2'b00,1'b0,3'b000,3'b000,3'b111,8'h00,2'b00,2'b00, 8'b00010011,2'd2,3'b000}, // R7 ignored
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h01,2'b00,2'b00, 8'b00110111,2'd2,3'b001}, // R7 R10 wake
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b10,2'b00, 8'b00110111,2'd2,3'b001}, // R9
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b01,2'b00, 8'b00110111,2'd2,3'b101}, // R10 rst pulse
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b00,2'b00, 8'b11110111,2'd2,3'b001}, // R10 one cycle
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b00,2'b01, 8'b11110111,2'd2,3'b000}, // R10 w1c
    {2'b01,1'b1,3'b110,3'b000,3'b000,8'h00,2'b00,2'b00, 8'b00000001,2'd2,3'b000}, // R8 shutdown
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'ha7,2'b00,2'b00, 8'b00000001,2'd2,3'b000}, // R8 disallowed
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h10,2'b00,2'b00, 8'b00110111,2'd2,3'b010}, // R8 rtc wakes
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b10,2'b00, 8'b00110111,2'd2,3'b010}, // R9
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b01,2'b00, 8'b00110111,2'd2,3'b110}, // R10 rst pulse
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b00,2'b00, 8'b11110111,2'd2,3'b010}, // R10
    {2'b10,1'b1,3'b011,3'b000,3'b000,8'h80,2'b00,2'b00, 8'b11110111,2'd2,3'b010}, // R11 standby blocked
    {2'b10,1'b1,3'b011,3'b000,3'b000,8'h00,2'b00,2'b10, 8'b00000011,2'd2,3'b000}, // R7 no ret, R10 clr
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h80,2'b00,2'b01, 8'b00110111,2'd2,3'b001}, // R10 set wins
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b11,2'b00, 8'b00110111,2'd2,3'b001}, // R9
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b01,2'b00, 8'b00110111,2'd2,3'b101}, // R10
    {2'b00,1'b0,3'b000,3'b000,3'b000,8'h00,2'b00,2'b00, 8'b11110111,2'd2,3'b001}  // R10
  };

  task automatic drive(input logic [36:0] v);
    sleepReq    = v[36] | v[35];
    sleepOnEvt  = v[36];
    deepSleep   = v[34];
    modeSel     = v[33:31];
    lpRegReq    = v[30];
    retainRam   = v[29];
    stopWakeHsi = v[28];
    irqPend     = v[27];
    evtPend     = v[26];
    extiWake    = v[25];
    wakeSrc     = v[24:17];
    regRdy      = v[16];
    oscRdy      = v[15];
    flagClr     = v[14:13];
  endtask

  function automatic logic [12:0] observed();
    return {cpuClkEn, periphClkEn, mainRegEn, lpRegEn, hsiEn, msiEn, lsiEn, lseEn,
            sysClkSel, sysRstReq, exitFlags[1], exitFlags[0]};
  endfunction

  task automatic check(input string req, input logic [12:0] exp);
    checks++;
    if (observed() !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, observed(), exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    drive('0);
    repeat (3) @(negedge clk);
    check("R1 in reset", 13'b11110111_10_000);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      #1;
      check($sformatf("row %0d", i), VEC[i][12:0]);
    end

    // R1: reset taken from inside a stop level with a flag set restores run
    @(negedge clk);
    drive({2'b01,1'b1,3'b001,3'b001,3'b000,8'h00,2'b00,2'b00,13'b0});
    @(posedge clk); #1;
    check("R5 stop1 hsi", 13'b00011011_01_001);
    @(negedge clk);
    drive('0);
    rstN = 1'b0;
    #1;
    check("R1 async reset", 13'b11110111_10_000);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", 13'b11110111_10_000);

    // R8: shutdown code 111 and the external-reset-pin line (bit 6)
    @(negedge clk);
    drive({2'b10,1'b1,3'b111,3'b000,3'b000,8'h00,2'b00,2'b00,13'b0});
    @(posedge clk); #1;
    check("R8 code 111", 13'b00000001_10_000);
    @(negedge clk);
    drive({2'b00,1'b0,3'b000,3'b000,3'b000,8'h40,2'b00,2'b00,13'b0});
    @(posedge clk); #1;
    check("R8 reset pin wakes", 13'b00110111_10_010);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule